// File: doc/BRIEF.md
# Wrapped Line Fill with Early Core Restart

This block services a read miss by pulling one complete cache line over a memory bus that is narrower than the line. The line is 32 bytes and the bus is 8 bytes wide, so a fill takes four bus transfers. The first transfer fetches the chunk that holds the missed byte. Each later transfer fetches the next chunk upward and wraps back to the start of the line. For example, a miss on byte 0x95 is fetched as 0x90, 0x98, 0x80, 0x88.

The critical chunk goes straight to the core as soon as it lands, so the core can restart while the rest of the line is still arriving. Every chunk is stored in a fill buffer at its own place in the line, whatever order it arrived in. After the last chunk lands, the controller drives the assembled line into the cache data array with a single write-enable pulse. A fill-done strobe marks that same cycle. Only one memory read is outstanding at a time. The request stays asserted, with a stable address, until the memory returns a response.

Top module: `linefill_cwf`

## Requirements
- R1: During and right after reset, busy, memReq, coreValid, cacheWe and fillDone are all low.
- R2: The first memory read of a fill addresses the chunk that holds missAddr: line base plus missAddr[4:3] times 8, with address bits [2:0] zero.
- R3: Reads follow chunk index (s + i) mod 4 for i = 0..3, where s = missAddr[4:3]. A miss at 0x95 reads 0x90, 0x98, 0x80, 0x88.
- R4: Each fill issues exactly four reads. A read holds memReq high and memRdAddr stable until a cycle with memRspValid high.
- R5: coreValid is high for exactly one cycle, the cycle after the first response is taken, and coreData then equals that response's data.
- R6: The written line holds the chunk of index k in bits [64k+63:64k], whatever the arrival order.
- R7: cacheWe is high for exactly one cycle, the cycle after the fourth response. fillDone is high in that same cycle, and cacheLineAddr then equals the 32-byte aligned miss address.
- R8: busy rises the cycle after a miss is accepted and stays high through the write cycle. A miss request that arrives while busy is ignored.
- R9: A memRspValid pulse with no fill in progress is ignored: busy, coreValid and cacheWe stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| missReq | input | 1 | Miss request, taken when not busy |
| missAddr | input | 32 | Byte address of the missed access |
| busy | output | 1 | Fill in progress |
| memReq | output | 1 | Memory read request, held until response |
| memRdAddr | output | 32 | Byte address of the requested chunk |
| memRspValid | input | 1 | Memory response strobe |
| memRspData | input | 64 | Memory response chunk |
| coreValid | output | 1 | One-cycle strobe for the critical chunk |
| coreData | output | 64 | Critical chunk for the core |
| cacheWe | output | 1 | Line write enable to the cache data array |
| cacheLineAddr | output | 32 | Aligned address of the line being written |
| cacheLineData | output | 256 | Assembled line |
| fillDone | output | 1 | Fill-complete pulse |

## Verification
busy is due one cycle after the edge that accepts a miss. coreValid is due one cycle after the edge that takes the first response, and cacheWe and fillDone one cycle after the edge that takes the fourth. The bench's memory model drives each response half a cycle before the edge that consumes it. At that moment it checks the request address against a scoreboard queue and records which strobe the following negative edge must show. The monitor compares every strobe at negative edges against those records, so a strobe that comes early, late or twice is reported. Response latency is varied from zero to three idle cycles.

// File: rtl/lf_pkg.sv
package lf_pkg;
  typedef enum logic [1:0] {
    FILL_IDLE  = 2'd0,
    FILL_FETCH = 2'd1,
    FILL_WRITE = 2'd2
  } fillState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // latch a new miss
    logic capture;   // store the arriving chunk
    logic critical;  // arriving chunk is the first one
  } fillStrobes_t;
endpackage

// File: rtl/lf_ctrl.sv
module lf_ctrl
  import lf_pkg::*;
#(
  parameter int CHUNKS = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        missReq,
  input  logic                        memRspValid,
  output logic                        busy,
  output logic                        memReq,
  output logic                        cacheWe,
  output logic                        fillDone,
  output fillStrobes_t                strb,
  output logic [$clog2(CHUNKS)-1:0]   cnt
);
  localparam int CB = $clog2(CHUNKS);
  localparam logic [CB-1:0] LAST = CB'(CHUNKS - 1);

  fillState_t state, stateNext;
  logic lastChunk;

  assign strb.load     = (state == FILL_IDLE) && missReq;
  assign strb.capture  = (state == FILL_FETCH) && memRspValid;
  assign strb.critical = strb.capture && (cnt == '0);
  assign lastChunk     = strb.capture && (cnt == LAST);

  always_comb begin
    stateNext = state;
    unique case (state)
      FILL_IDLE:  if (missReq)   stateNext = FILL_FETCH;
      FILL_FETCH: if (lastChunk) stateNext = FILL_WRITE;
      FILL_WRITE:                stateNext = FILL_IDLE;
      default:                   stateNext = FILL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= FILL_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      if (strb.load)         cnt <= '0;
      else if (strb.capture) cnt <= cnt + 1'b1;
    end
  end

  assign busy     = (state != FILL_IDLE);
  assign memReq   = (state == FILL_FETCH);
  assign cacheWe  = (state == FILL_WRITE);
  assign fillDone = cacheWe;

  // R4
  req_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memRspValid |=> memReq);
  // R7
  we_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    cacheWe |=> !cacheWe && !busy);
  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(missReq));
endmodule

// File: rtl/lf_datapath.sv
module lf_datapath
  import lf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BUS_BYTES  = 8,
  parameter int LINE_BYTES = 32
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  fillStrobes_t                           strb,
  input  logic [$clog2(LINE_BYTES/BUS_BYTES)-1:0] cnt,
  input  logic [ADDR_W-1:0]                      missAddr,
  input  logic [BUS_BYTES*8-1:0]                 memRspData,
  output logic [ADDR_W-1:0]                      memRdAddr,
  output logic                                   coreValid,
  output logic [BUS_BYTES*8-1:0]                 coreData,
  output logic [ADDR_W-1:0]                      cacheLineAddr,
  output logic [LINE_BYTES*8-1:0]                cacheLineData
);
  localparam int CHUNKS = LINE_BYTES / BUS_BYTES;
  localparam int CB     = $clog2(CHUNKS);
  localparam int BB     = $clog2(BUS_BYTES);
  localparam int OFF    = $clog2(LINE_BYTES);
  localparam int BUS_W  = BUS_BYTES * 8;
  localparam int TAG_W  = ADDR_W - OFF;

  logic [TAG_W-1:0]                 lineBase;
  logic [CB-1:0]                    startIdx;
  logic [CB-1:0]                    idx;
  logic [CHUNKS-1:0][BUS_W-1:0]     fillBuf;

  // wrap falls out of the CB-bit sum
  assign idx = startIdx + cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineBase  <= '0;
      startIdx  <= '0;
      coreValid <= 1'b0;
      coreData  <= '0;
    end else begin
      if (strb.load) begin
        lineBase <= missAddr[ADDR_W-1:OFF];
        startIdx <= missAddr[OFF-1:BB];
      end
      coreValid <= strb.critical;
      if (strb.critical) coreData <= memRspData;
    end
  end

  for (genvar g = 0; g < CHUNKS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                 fillBuf[g] <= '0;
      else if (strb.capture && idx == CB'(g))    fillBuf[g] <= memRspData;
    end
  end

  assign memRdAddr     = {lineBase, idx, {BB{1'b0}}};
  assign cacheLineAddr = {lineBase, {OFF{1'b0}}};
  assign cacheLineData = fillBuf;

  // R5
  core_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    coreValid |=> !coreValid);
  // R2
  first_chunk_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> memRdAddr[OFF-1:0] == {$past(missAddr[OFF-1:BB]), {BB{1'b0}}});
endmodule

// File: rtl/linefill_cwf.sv
module linefill_cwf
  import lf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BUS_BYTES  = 8,
  parameter int LINE_BYTES = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    missReq,
  input  logic [ADDR_W-1:0]       missAddr,
  output logic                    busy,
  output logic                    memReq,
  output logic [ADDR_W-1:0]       memRdAddr,
  input  logic                    memRspValid,
  input  logic [BUS_BYTES*8-1:0]  memRspData,
  output logic                    coreValid,
  output logic [BUS_BYTES*8-1:0]  coreData,
  output logic                    cacheWe,
  output logic [ADDR_W-1:0]       cacheLineAddr,
  output logic [LINE_BYTES*8-1:0] cacheLineData,
  output logic                    fillDone
);
  localparam int CHUNKS = LINE_BYTES / BUS_BYTES;
  localparam int CB     = $clog2(CHUNKS);

  fillStrobes_t  strb;
  logic [CB-1:0] cnt;

  lf_ctrl #(.CHUNKS(CHUNKS)) ctrl_i (
    .clk(clk), .rstN(rstN), .missReq(missReq), .memRspValid(memRspValid),
    .busy(busy), .memReq(memReq), .cacheWe(cacheWe), .fillDone(fillDone),
    .strb(strb), .cnt(cnt)
  );

  lf_datapath #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES), .LINE_BYTES(LINE_BYTES)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cnt(cnt), .missAddr(missAddr),
    .memRspData(memRspData), .memRdAddr(memRdAddr), .coreValid(coreValid),
    .coreData(coreData), .cacheLineAddr(cacheLineAddr), .cacheLineData(cacheLineData)
  );
endmodule

// File: tb/linefill_cwf_tb_top.sv
module linefill_cwf_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic missReq = 1'b0;
  logic [31:0] missAddr = '0;
  logic busy, memReq, coreValid, cacheWe, fillDone;
  logic [31:0] memRdAddr, cacheLineAddr;
  logic memRspValid = 1'b0;
  logic [63:0] memRspData = '0;
  logic [63:0] coreData;
  logic [255:0] cacheLineData;

  always #4 clk = ~clk;

  linefill_cwf dut_i (
    .clk(clk), .rstN(rstN), .missReq(missReq), .missAddr(missAddr), .busy(busy),
    .memReq(memReq), .memRdAddr(memRdAddr), .memRspValid(memRspValid),
    .memRspData(memRspData), .coreValid(coreValid), .coreData(coreData),
    .cacheWe(cacheWe), .cacheLineAddr(cacheLineAddr), .cacheLineData(cacheLineData),
    .fillDone(fillDone)
  );

  int nChecks = 0;
  int nFail = 0;
  logic [31:0]  expAddrQ[$];
  logic [63:0]  expCritQ[$];
  logic [255:0] expLineQ[$];
  logic [31:0]  expBaseQ[$];
  int  memLat = 0;
  int  waitCnt = 0;
  int  xfer = 0;
  logic [31:0] seed = 32'h1357_9bdf;
  bit  expCoreNext = 0;
  bit  expWeNext = 0;
  bit  strayReq = 0;
  bit  monOn = 0;
  bit  finished = 0;

  function automatic logic [63:0] memData(input logic [31:0] a, input logic [31:0] s);
    return {a ^ s, (~a) + s};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model: checks request address when it answers
  initial begin
    forever begin
      @(negedge clk); #1;
      if (memRspValid) begin
        memRspValid = 1'b0;
        waitCnt = 0;
      end else if (memReq) begin
        if (waitCnt >= memLat) begin
          if (expAddrQ.size() == 0) chk(0, "R4", "extra read", memRdAddr, 0);
          else begin
            logic [31:0] ea;
            ea = expAddrQ.pop_front();
            // R2 (first) and R3 (order)
            chk(memRdAddr == ea, (xfer == 0) ? "R2" : "R3", "read address", memRdAddr, ea);
          end
          memRspData  = memData(memRdAddr, seed);
          memRspValid = 1'b1;
          expCoreNext = (xfer == 0);
          expWeNext   = (xfer == 3);
          xfer++;
        end else begin
          waitCnt++;
        end
      end else if (strayReq) begin
        memRspData  = 64'hdead_beef_0bad_f00d;
        memRspValid = 1'b1;
        strayReq    = 1'b0;
      end
    end
  end

  // monitor: strobes and results against the scoreboard
  always @(negedge clk) begin
    if (monOn) begin
      if (coreValid !== expCoreNext) chk(0, "R5", "coreValid timing", coreValid, expCoreNext);
      if (coreValid) begin
        logic [63:0] ec;
        ec = (expCritQ.size() != 0) ? expCritQ.pop_front() : 64'hx;
        chk(coreData === ec, "R5", "critical chunk", coreData, ec);
      end
      if (cacheWe !== expWeNext) chk(0, "R7", "cacheWe timing", cacheWe, expWeNext);
      if (fillDone !== cacheWe) chk(0, "R7", "fillDone with cacheWe", fillDone, cacheWe);
      if (cacheWe) begin
        logic [255:0] el;
        logic [31:0] eb;
        el = (expLineQ.size() != 0) ? expLineQ.pop_front() : 256'hx;
        eb = (expBaseQ.size() != 0) ? expBaseQ.pop_front() : 32'hx;
        chk(cacheLineData === el, "R6", "line data", cacheLineData, el);
        chk(cacheLineAddr === eb, "R7", "line address", cacheLineAddr, eb);
      end
      expCoreNext = 0;
      expWeNext   = 0;
    end
  end

  // driver: pushes expectations, issues the miss, waits for the write
  task automatic doMiss(input logic [31:0] a, input int lat, input bit intrude);
    logic [31:0] base;
    logic [1:0]  s;
    logic [255:0] line;
    @(negedge clk);
    while (busy) @(negedge clk);
    chk(busy == 1'b0, "R8", "idle before miss", busy, 0);
    base = a & ~32'h1f;
    s    = a[4:3];
    seed = seed * 32'd1103515245 + 32'd12345;
    for (int i = 0; i < 4; i++) begin
      logic [1:0] k;
      k = s + 2'(i);
      expAddrQ.push_back(base + {27'd0, k, 3'd0});
    end
    for (int k = 0; k < 4; k++) line[64*k +: 64] = memData(base + 32'(8*k), seed);
    expCritQ.push_back(memData(base + {27'd0, s, 3'd0}, seed));
    expLineQ.push_back(line);
    expBaseQ.push_back(base);
    memLat = lat;
    xfer = 0;
    #1; missReq = 1'b1; missAddr = a;
    @(negedge clk);
    chk(busy == 1'b1, "R8", "busy after accept", busy, 1);
    #1; missReq = 1'b0;
    if (intrude) begin
      @(negedge clk); #1; missReq = 1'b1; missAddr = a ^ 32'h0000_0048;
      @(negedge clk);
      chk(busy == 1'b1, "R8", "busy during intruding miss", busy, 1);
      #1; missReq = 1'b0;
    end
    do @(negedge clk); while (!cacheWe);
    @(negedge clk);
    chk(busy == 1'b0, "R8", "busy low after write", busy, 0);
    chk(xfer == 4 && expAddrQ.size() == 0, "R4", "reads per fill", xfer, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk({busy, memReq, coreValid, cacheWe, fillDone} == 5'b0, "R1", "outputs in reset",
        {busy, memReq, coreValid, cacheWe, fillDone}, 0);
    #1; rstN = 1'b1;
    @(negedge clk);
    chk({busy, memReq, coreValid, cacheWe, fillDone} == 5'b0, "R1", "outputs after reset",
        {busy, memReq, coreValid, cacheWe, fillDone}, 0);
    monOn = 1;
    doMiss(32'h0000_0095, 0, 0);   // R3 example order 90,98,80,88
    doMiss(32'h0000_0080, 2, 0);   // start at chunk 0
    doMiss(32'h0000_009f, 1, 0);   // last byte of chunk 3
    doMiss(32'h1234_5678, 3, 0);
    doMiss(32'hffff_ffe9, 0, 1);   // R8 intruding miss ignored
    // R9 stray response while idle
    @(negedge clk); #1; strayReq = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk({busy, coreValid, cacheWe} == 3'b0, "R9", "stray response ignored",
          {busy, coreValid, cacheWe}, 0);
    end
    for (int j = 0; j < 6; j++) doMiss(32'h0040_0000 + 32'(j * 8 + j * 64 + 3), j % 4, j[0]);
    repeat (4) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end
endmodule